// File: doc/BRIEF.md
# Double-to-Int32 Converter

This block turns a double-precision IEEE-754 operand into a signed 32-bit integer. It has two conversion modes. Truncate mode chops the value toward zero. Round mode moves the value half a unit away from zero and then truncates, so exact halves round away from zero, not to even. The result appears on a register one clock after the operand is accepted.

Inputs with no integer meaning never trap. These are NaNs, infinities and any value whose magnitude exceeds 2147483647. All of them return the fixed integer-indefinite code 0x80000000. Zeros and denormals of either sign return 0. The range test uses the magnitude before rounding. So 2147483647.5 gives the indefinite code in both modes, even though it would round to 2^31 or truncate to 2147483647.

A pipeline places this block after operand fetch. It drives the operand and the mode with a valid strobe, and it takes the result with the delayed strobe.

Top module: `f2i_conv`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and result_o is 0.
- R2: valid_o is valid_i delayed by one clock. result_o loads only on a clock where valid_i is 1 and holds its value otherwise.
- R3: With trunc_i = 1, an in-range operand converts by discarding its fraction (toward zero). Example: 3.7 gives 3 and 1000000000.9 gives 1000000000.
- R4: With trunc_i = 0, an in-range operand converts as trunc(x + 0.5) for x >= 0 and trunc(x - 0.5) for x < 0. Example: 2.5 gives 3, -0.5 gives -1 and 0.49 gives 0.
- R5: An operand with exponent field all ones and a nonzero fraction field (NaN) gives 0x80000000 in either mode.
- R6: An operand with exponent field all ones and a zero fraction field (+inf or -inf) gives 0x80000000 in either mode.
- R7: An operand whose unrounded magnitude is greater than 2147483647 gives 0x80000000. Examples are 2147483647.5, -2147483648.0 and 1e12. The operand 2147483647.0 gives 0x7fffffff.
- R8: An operand with exponent field zero (zero or denormal, either sign) gives 0 in either mode.
- R9: Negative results come out as 32-bit two's complement. Example: -3.7 truncated gives 0xfffffffd and -2147483647.0 gives 0x80000001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand strobe |
| trunc_i | input | 1 | 1 = truncate toward zero, 0 = round half away from zero |
| op_i | input | 64 | Double-precision operand (bit 63 sign, bits 62:52 exponent, bits 51:0 fraction) |
| valid_o | output | 1 | Result strobe, one clock after valid_i |
| result_o | output | 32 | Signed integer result or 0x80000000 |

## Verification
The hardest case to reach is the narrow band just under 2^31. There, a fraction bit alone decides between 0x7fffffff and the indefinite code, and a rounding carry could otherwise overflow. The bench builds exact operands such as 2147483647.0, 2147483647.5 and -2147483648.0, and applies each in both modes. It also writes raw bit patterns for denormals, negative zero, NaN and the infinities, because these cannot come from ordinary real literals. Exact halves on both sides of zero exercise the tie rule.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  typedef enum logic {
    MODE_ROUND = 1'b0,
    MODE_TRUNC = 1'b1
  } cvt_mode_e;

  typedef struct packed {
    logic neg;       // sign of operand
    logic spec;      // exponent all ones: NaN or infinity
    logic zero_den;  // exponent zero: zero or denormal
  } op_class_t;
endpackage

// File: rtl/f2i_classify.sv
module f2i_classify
  import f2i_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  localparam int OP_W = 1 + EXP_W + MAN_W,
  localparam int UE_W = EXP_W + 2
) (
  input  logic [OP_W-1:0]        op_i,
  output op_class_t              cls_o,
  output logic signed [UE_W-1:0] uexp_o,
  output logic [MAN_W:0]         sig_o
);
  localparam logic signed [UE_W-1:0] BIAS = UE_W'(2 ** (EXP_W - 1) - 1);

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;

  always_comb begin
    exp_f          = op_i[OP_W-2 -: EXP_W];
    man_f          = op_i[MAN_W-1:0];
    cls_o.neg      = op_i[OP_W-1];
    cls_o.spec     = &exp_f;
    cls_o.zero_den = ~|exp_f;
    sig_o          = {1'b1, man_f};
    uexp_o         = $signed({2'b00, exp_f}) - BIAS;
  end
endmodule

// File: rtl/f2i_align.sv
module f2i_align #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  parameter int INT_W = 32,
  localparam int UE_W   = EXP_W + 2,
  localparam int SH_W   = $clog2(INT_W),
  localparam int MAG_W  = INT_W - 1,
  localparam int WIDE_W = MAG_W + MAN_W + 1
) (
  input  logic signed [UE_W-1:0] uexp_i,
  input  logic [MAN_W:0]         sig_i,
  output logic [MAG_W-1:0]       mag_o,
  output logic                   rbit_o,
  output logic                   sticky_o,
  output logic                   big_o
);
  localparam logic signed [UE_W-1:0] TOP_E = UE_W'(INT_W - 1);
  localparam logic signed [UE_W-1:0] LOW_E = -1;

  logic              in_win;
  logic [SH_W-1:0]   sh;
  logic [WIDE_W-1:0] wide;

  // wide holds |x| * 2^(MAN_W+1): integer part above the round bit
  always_comb begin
    big_o    = uexp_i >= TOP_E;
    in_win   = (uexp_i >= LOW_E) && !big_o;
    sh       = in_win ? SH_W'(uexp_i - LOW_E) : '0;
    wide     = in_win ? ({{MAG_W{1'b0}}, sig_i} << sh) : '0;
    mag_o    = wide[WIDE_W-1 -: MAG_W];
    rbit_o   = wide[MAN_W];
    sticky_o = |wide[MAN_W-1:0];
  end
endmodule

// File: rtl/f2i_finish.sv
module f2i_finish
  import f2i_pkg::*;
#(
  parameter int INT_W = 32,
  localparam int MAG_W = INT_W - 1
) (
  input  op_class_t          cls_i,
  input  logic [MAG_W-1:0]   mag_i,
  input  logic               rbit_i,
  input  logic               sticky_i,
  input  logic               big_i,
  input  cvt_mode_e          mode_i,
  output logic [INT_W-1:0]   res_o
);
  localparam logic [INT_W-1:0] INDEF = {1'b1, {MAG_W{1'b0}}};

  logic             ovf;
  logic             inc;
  logic [INT_W-1:0] sum;

  always_comb begin
    // range test on the unrounded magnitude
    ovf = big_i | (&mag_i & (rbit_i | sticky_i));
    inc = (mode_i == MODE_ROUND) & rbit_i;
    sum = {1'b0, mag_i} + INT_W'(inc);
    if (cls_i.spec || ovf)   res_o = INDEF;
    else if (cls_i.zero_den) res_o = '0;
    else if (cls_i.neg)      res_o = -sum;
    else                     res_o = sum;
  end
endmodule

// File: rtl/f2i_conv.sv
module f2i_conv
  import f2i_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  parameter int INT_W = 32,
  localparam int OP_W  = 1 + EXP_W + MAN_W,
  localparam int UE_W  = EXP_W + 2,
  localparam int MAG_W = INT_W - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             trunc_i,
  input  logic [OP_W-1:0]  op_i,
  output logic             valid_o,
  output logic [INT_W-1:0] result_o
);
  op_class_t              cls;
  logic signed [UE_W-1:0] uexp;
  logic [MAN_W:0]         sig;
  logic [MAG_W-1:0]       mag;
  logic                   rbit, sticky, big;
  logic [INT_W-1:0]       res_d;
  cvt_mode_e              mode;

  assign mode = trunc_i ? MODE_TRUNC : MODE_ROUND;

  f2i_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_classify (
    .op_i  (op_i),
    .cls_o (cls),
    .uexp_o(uexp),
    .sig_o (sig)
  );

  f2i_align #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_align (
    .uexp_i  (uexp),
    .sig_i   (sig),
    .mag_o   (mag),
    .rbit_o  (rbit),
    .sticky_o(sticky),
    .big_o   (big)
  );

  f2i_finish #(.INT_W(INT_W)) u_finish (
    .cls_i   (cls),
    .mag_i   (mag),
    .rbit_i  (rbit),
    .sticky_i(sticky),
    .big_i   (big),
    .mode_i  (mode),
    .res_o   (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= res_d;
    end
  end
endmodule

// File: rtl/f2i_conv_chk.sv
module f2i_conv_chk #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  parameter int INT_W = 32,
  localparam int OP_W = 1 + EXP_W + MAN_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [OP_W-1:0]  op_i,
  input logic             valid_o,
  input logic [INT_W-1:0] result_o
);
  localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [EXP_W-1:0] E_BIG = EXP_W'(2 ** (EXP_W - 1) - 1 + INT_W - 1);

  logic [EXP_W-1:0] e;
  logic             man_nz;
  assign e      = op_i[OP_W-2 -: EXP_W];
  assign man_nz = |op_i[MAN_W-1:0];

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R2
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R2
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o)); // R2
  AST_NAN_INDEF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && &e && man_nz) |=> result_o == INDEF); // R5
  AST_INF_INDEF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && &e && !man_nz) |=> result_o == INDEF); // R6
  AST_BIG_INDEF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !(&e) && e >= E_BIG) |=> result_o == INDEF); // R7
  AST_TINY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && e == '0) |=> result_o == '0); // R8
endmodule

bind f2i_conv f2i_conv_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .op_i    (op_i),
  .valid_o (valid_o),
  .result_o(result_o)
);

// File: tb/f2i_conv_tb_top.sv
module f2i_conv_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        trunc_i = 1'b0;
  logic [63:0] op_i = '0;
  logic        valid_o;
  logic [31:0] result_o;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  localparam logic [31:0] INDEF = 32'h8000_0000;

  always #10 clk_i = ~clk_i;

  f2i_conv dut_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .trunc_i (trunc_i),
    .op_i    (op_i),
    .valid_o (valid_o),
    .result_o(result_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cvt(input logic [63:0] bits, input bit t, input logic [31:0] exp,
                     input string req);
    @(negedge clk_i);
    op_i = bits; trunc_i = t; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    check(req, result_o, exp);
    check({req, " R2 valid"}, {31'b0, valid_o}, 32'd1);
  endtask

  task automatic t_reset;
    check("R1 valid_o", {31'b0, valid_o}, 32'd0);
    check("R1 result_o", result_o, 32'd0);
  endtask

  task automatic t_trunc;
    cvt($realtobits(3.7), 1'b1, 32'd3, "R3 3.7");
    cvt($realtobits(1000000000.9), 1'b1, 32'h3B9A_CA00, "R3 1e9+0.9");
    cvt($realtobits(0.99), 1'b1, 32'd0, "R3 0.99");
    cvt($realtobits(-3.7), 1'b1, 32'hFFFF_FFFD, "R9 R3 -3.7");
  endtask

  task automatic t_round;
    cvt($realtobits(2.5), 1'b0, 32'd3, "R4 2.5");
    cvt($realtobits(-2.5), 1'b0, 32'hFFFF_FFFD, "R4 R9 -2.5");
    cvt($realtobits(0.5), 1'b0, 32'd1, "R4 0.5");
    cvt($realtobits(-0.5), 1'b0, 32'hFFFF_FFFF, "R4 -0.5");
    cvt($realtobits(0.49), 1'b0, 32'd0, "R4 0.49");
    cvt($realtobits(2.49), 1'b0, 32'd2, "R4 2.49");
    cvt($realtobits(-7.6), 1'b0, 32'hFFFF_FFF8, "R4 -7.6");
  endtask

  task automatic t_special;
    cvt(64'h7FF8_0000_0000_0000, 1'b0, INDEF, "R5 qnan round");
    cvt(64'hFFF0_0000_0000_0001, 1'b1, INDEF, "R5 snan trunc");
    cvt(64'h7FF0_0000_0000_0000, 1'b0, INDEF, "R6 +inf");
    cvt(64'hFFF0_0000_0000_0000, 1'b1, INDEF, "R6 -inf");
  endtask

  task automatic t_range;
    cvt($realtobits(2147483647.0), 1'b0, 32'h7FFF_FFFF, "R7 max round");
    cvt($realtobits(2147483647.0), 1'b1, 32'h7FFF_FFFF, "R7 max trunc");
    cvt($realtobits(2147483647.5), 1'b1, INDEF, "R7 max+.5 trunc");
    cvt($realtobits(2147483647.5), 1'b0, INDEF, "R7 max+.5 round");
    cvt($realtobits(-2147483648.0), 1'b1, INDEF, "R7 -2^31");
    cvt($realtobits(1.0e12), 1'b0, INDEF, "R7 1e12");
    cvt($realtobits(-2147483647.0), 1'b0, 32'h8000_0001, "R9 R7 -max");
  endtask

  task automatic t_tiny;
    cvt(64'h0000_0000_0000_0000, 1'b0, 32'd0, "R8 +0");
    cvt(64'h8000_0000_0000_0000, 1'b1, 32'd0, "R8 -0");
    cvt(64'h0000_0000_0000_0001, 1'b0, 32'd0, "R8 denorm");
    cvt(64'h800F_FFFF_FFFF_FFFF, 1'b0, 32'd0, "R8 -denorm");
  endtask

  task automatic t_hold;
    cvt($realtobits(9.2), 1'b1, 32'd9, "R2 load");
    @(negedge clk_i);
    op_i = 64'h7FF8_0000_0000_0000; trunc_i = 1'b0;
    @(negedge clk_i);
    check("R2 hold result", result_o, 32'd9);
    check("R2 idle valid", {31'b0, valid_o}, 32'd0);
  endtask

  initial begin
    repeat (10000) @(posedge clk_i);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog R2 actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_trunc();
    t_round();
    t_special();
    t_range();
    t_tiny();
    t_hold();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule